// File: doc/BRIEF.md
# SDRAM Bank Precharge Tracker

This block keeps the row state of four SDRAM banks and turns bank-level requests into command-pin patterns. Each clock cycle it accepts one request. The request can be an idle request, a row activation, a column read or write, a precharge of one bank, or a precharge of every bank. It checks the request against the state of the target bank. A legal request drives the matching command onto the registered pins one cycle later. An illegal request drives no command and raises an error pulse instead.

Each bank has its own recovery countdown. A precharge loads that countdown from the row-precharge time `trpCycles`, which is sampled when the precharge is accepted. While the countdown runs, the bank's ready flag stays low and the bank cannot be activated. The address line that selects all banks is driven high only for an all-bank precharge. For a single-bank precharge it is low and the bank-select pins carry the bank index. A precharge can be sent to an open bank at any time, for example to cut a burst short. It can also be sent to a bank that is already idle, which restarts that bank's countdown.

Top module: `sdram_prechg_tracker`

## Requirements
- R1: After reset the pins show NOP (csN=0, rasN=1, casN=1, weN=1, a10=0, ba=0), bankReady is 4'b1111 and errPulse is low.
- R2: A single-bank precharge request (reqOp=4) produces PRECHARGE (csN=0, rasN=0, casN=1, weN=0) one cycle later, with a10=0 and ba equal to reqBank. It closes only that bank.
- R3: An all-bank precharge request (reqOp=5) produces PRECHARGE with a10=1 and ba=0. It closes every bank and restarts every bank's countdown.
- R4: After a PRECHARGE appears on the pins, the targeted bank's ready flag is low and rises max(trpCycles,1)-1 cycles later. The earliest legal ACTIVE therefore appears max(trpCycles,1) cycles after the PRECHARGE.
- R5: An activate request (reqOp=1) to a ready bank produces ACTIVE (csN=0, rasN=0, casN=1, weN=1) with ba=reqBank one cycle later. The bank becomes open and its ready flag drops.
- R6: An activate request to a bank that is open or still recovering raises errPulse for one cycle. The pins show NOP and the bank state is unchanged.
- R7: A read (reqOp=2) or write (reqOp=3) request to an open bank produces READ (csN=0, rasN=1, casN=0, weN=1) or WRITE (csN=0, rasN=1, casN=0, weN=0) with a10=0 and ba=reqBank.
- R8: A read or write request to an idle or recovering bank raises errPulse for one cycle, and the pins show NOP.
- R9: A precharge to a bank that is already idle or recovering is legal. It reloads that bank's countdown from the current trpCycles.
- R10: reqOp values 0, 6 and 7 produce NOP on the pins with a10=0 and ba=0, and they leave every bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqOp | input | 3 | Request kind: 0 none, 1 activate, 2 read, 3 write, 4 precharge one, 5 precharge all |
| reqBank | input | 2 | Target bank index |
| trpCycles | input | TRP_W | Row-precharge time in clock cycles |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| a10 | output | 1 | All-bank select for precharge |
| ba | output | 2 | Bank select |
| bankReady | output | 4 | Per-bank flag: idle and recovery done |
| errPulse | output | 1 | One-cycle flag for a rejected request |

## Verification
Two things can fall on the same cycle: the expiry of a bank's countdown and a precharge that reloads it. The bench provokes this by repeating a precharge to a recovering bank on the last cycle before its ready flag would rise. The ready flag must then stay low for a full new window, and an activation attempted at the old expiry point must be rejected. A second case is an activation aimed at the exact cycle the countdown ends. It must be accepted, not rejected. Random traffic with varied trpCycles values repeats both kinds of case many times against a per-bank reference model kept in the bench.

// File: rtl/prechg_pkg.sv
package prechg_pkg;
  localparam int BANK_W    = 2;
  localparam int NUM_BANKS = 1 << BANK_W;

  localparam logic [2:0] OP_NONE    = 3'd0;
  localparam logic [2:0] OP_ACT     = 3'd1;
  localparam logic [2:0] OP_READ    = 3'd2;
  localparam logic [2:0] OP_WRITE   = 3'd3;
  localparam logic [2:0] OP_PRE_ONE = 3'd4;
  localparam logic [2:0] OP_PRE_ALL = 3'd5;

  // csN, rasN, casN, weN
  typedef struct packed {
    logic csN;
    logic rasN;
    logic casN;
    logic weN;
  } cmdPinsT;

  localparam cmdPinsT CMD_NOP   = '{csN: 1'b0, rasN: 1'b1, casN: 1'b1, weN: 1'b1};
  localparam cmdPinsT CMD_ACT   = '{csN: 1'b0, rasN: 1'b0, casN: 1'b1, weN: 1'b1};
  localparam cmdPinsT CMD_PRE   = '{csN: 1'b0, rasN: 1'b0, casN: 1'b1, weN: 1'b0};
  localparam cmdPinsT CMD_READ  = '{csN: 1'b0, rasN: 1'b1, casN: 1'b0, weN: 1'b1};
  localparam cmdPinsT CMD_WRITE = '{csN: 1'b0, rasN: 1'b1, casN: 1'b0, weN: 1'b0};

  // strobes from control to the bank-state datapath
  typedef struct packed {
    logic [NUM_BANKS-1:0] closeMask;
    logic [NUM_BANKS-1:0] openMask;
  } bankStrobeT;
endpackage

// File: rtl/prechg_bank_timer.sv
module prechg_bank_timer #(
  parameter int TRP_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             closeStb,
  input  logic             openStb,
  input  logic [TRP_W-1:0] loadVal,
  output logic             isOpen,
  output logic             isReady
);
  logic [TRP_W-1:0] cntQ;
  logic             openQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      openQ <= 1'b0;
      cntQ  <= '0;
    end else if (closeStb) begin
      openQ <= 1'b0;
      cntQ  <= loadVal;
    end else begin
      if (openStb) openQ <= 1'b1;
      if (cntQ != '0) cntQ <= cntQ - 1'b1;
    end
  end

  assign isOpen  = openQ;
  assign isReady = !openQ && (cntQ == '0);

  // R5: an accepted activation leaves the bank open and not ready
  p_open_after_act_r5: assert property (@(posedge clk) disable iff (!rstN)
    (openStb && !closeStb) |=> (isOpen && !isReady));

  // R9: a precharge with a nonzero reload blocks reactivation next cycle
  p_reload_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    (closeStb && loadVal != '0) |=> !isReady);

  // R2: a precharge always leaves the bank closed
  p_close_r2: assert property (@(posedge clk) disable iff (!rstN)
    closeStb |=> !isOpen);
endmodule

// File: rtl/prechg_bank_state.sv
module prechg_bank_state
  import prechg_pkg::*;
#(
  parameter int TRP_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bankStrobeT           strobe,
  input  logic [TRP_W-1:0]     trpCycles,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic [NUM_BANKS-1:0] bankReady
);
  // reload one less than tRP so that ACTIVE lands exactly tRP after PRECHARGE
  logic [TRP_W-1:0] loadVal;
  assign loadVal = (trpCycles == '0) ? '0 : trpCycles - 1'b1;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    prechg_bank_timer #(.TRP_W(TRP_W)) u_timer (
      .clk     (clk),
      .rstN    (rstN),
      .closeStb(strobe.closeMask[b]),
      .openStb (strobe.openMask[b]),
      .loadVal (loadVal),
      .isOpen  (bankOpen[b]),
      .isReady (bankReady[b])
    );
  end

  // R6: control never opens more than one bank per cycle
  p_single_open_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.openMask));
endmodule

// File: rtl/prechg_ctrl.sv
module prechg_ctrl
  import prechg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           reqOp,
  input  logic [BANK_W-1:0]    reqBank,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic [NUM_BANKS-1:0] bankReady,
  output bankStrobeT           strobe,
  output cmdPinsT              cmdQ,
  output logic                 a10Q,
  output logic [BANK_W-1:0]    baQ,
  output logic                 errQ
);
  logic [NUM_BANKS-1:0] bankOh;
  cmdPinsT              cmdD;
  logic                 a10D;
  logic [BANK_W-1:0]    baD;
  logic                 errD;

  assign bankOh = NUM_BANKS'(1) << reqBank;

  always_comb begin
    strobe = '0;
    cmdD   = CMD_NOP;
    a10D   = 1'b0;
    baD    = '0;
    errD   = 1'b0;
    case (reqOp)
      OP_ACT: begin
        if (bankReady[reqBank]) begin
          strobe.openMask = bankOh;
          cmdD = CMD_ACT;
          baD  = reqBank;
        end else begin
          errD = 1'b1;
        end
      end
      OP_READ, OP_WRITE: begin
        if (bankOpen[reqBank]) begin
          cmdD = (reqOp == OP_READ) ? CMD_READ : CMD_WRITE;
          baD  = reqBank;
        end else begin
          errD = 1'b1;
        end
      end
      OP_PRE_ONE: begin
        strobe.closeMask = bankOh;
        cmdD = CMD_PRE;
        baD  = reqBank;
      end
      OP_PRE_ALL: begin
        strobe.closeMask = '1;
        cmdD = CMD_PRE;
        a10D = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ <= CMD_NOP;
      a10Q <= 1'b0;
      baQ  <= '0;
      errQ <= 1'b0;
    end else begin
      cmdQ <= cmdD;
      a10Q <= a10D;
      baQ  <= baD;
      errQ <= errD;
    end
  end

  logic isActPin, isRwPin, isPrePin;
  assign isActPin = (cmdQ == CMD_ACT);
  assign isRwPin  = (cmdQ == CMD_READ) || (cmdQ == CMD_WRITE);
  assign isPrePin = (cmdQ == CMD_PRE);

  // R5: ACTIVE only reaches the pins for a bank that was ready
  p_act_needs_ready_r5: assert property (@(posedge clk) disable iff (!rstN)
    isActPin |-> ($past(bankReady[reqBank]) && baQ == $past(reqBank)));

  // R7: column commands only for an open bank
  p_rw_needs_open_r7: assert property (@(posedge clk) disable iff (!rstN)
    isRwPin |-> $past(bankOpen[reqBank]));

  // R8: a rejected request drives no command
  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    errQ |-> (cmdQ == CMD_NOP));

  // R3: after an all-bank precharge no bank is open
  p_all_closed_r3: assert property (@(posedge clk) disable iff (!rstN)
    (isPrePin && a10Q) |-> (bankOpen == '0 && baQ == '0));
endmodule

// File: rtl/sdram_prechg_tracker.sv
module sdram_prechg_tracker
  import prechg_pkg::*;
#(
  parameter int TRP_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           reqOp,
  input  logic [BANK_W-1:0]    reqBank,
  input  logic [TRP_W-1:0]     trpCycles,
  output logic                 csN,
  output logic                 rasN,
  output logic                 casN,
  output logic                 weN,
  output logic                 a10,
  output logic [BANK_W-1:0]    ba,
  output logic [NUM_BANKS-1:0] bankReady,
  output logic                 errPulse
);
  bankStrobeT           strobe;
  cmdPinsT              cmdQ;
  logic [NUM_BANKS-1:0] bankOpen;

  prechg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqOp    (reqOp),
    .reqBank  (reqBank),
    .bankOpen (bankOpen),
    .bankReady(bankReady),
    .strobe   (strobe),
    .cmdQ     (cmdQ),
    .a10Q     (a10),
    .baQ      (ba),
    .errQ     (errPulse)
  );

  prechg_bank_state #(.TRP_W(TRP_W)) u_state (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .trpCycles(trpCycles),
    .bankOpen (bankOpen),
    .bankReady(bankReady)
  );

  assign csN  = cmdQ.csN;
  assign rasN = cmdQ.rasN;
  assign casN = cmdQ.casN;
  assign weN  = cmdQ.weN;
endmodule

// File: tb/sdram_prechg_tracker_test.sv
module sdram_prechg_tracker_test;
  localparam int CLK_PERIOD = 10;
  localparam int TRP_W      = 4;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] reqOp = 3'd0;
  logic [1:0] reqBank = 2'd0;
  logic [TRP_W-1:0] trpCycles = 4'd3;
  logic csN, rasN, casN, weN, a10, errPulse;
  logic [1:0] ba;
  logic [3:0] bankReady;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model
  bit mOpen[4];
  int mCnt[4];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_prechg_tracker #(.TRP_W(TRP_W)) uut (
    .clk(clk), .rstN(rstN), .reqOp(reqOp), .reqBank(reqBank), .trpCycles(trpCycles),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN), .a10(a10), .ba(ba),
    .bankReady(bankReady), .errPulse(errPulse)
  );

  function automatic bit mReady(int b);
    return !mOpen[b] && mCnt[b] == 0;
  endfunction

  function automatic logic [3:0] mReadyVec();
    logic [3:0] v;
    for (int b = 0; b < 4; b++) v[b] = mReady(b);
    return v;
  endfunction

  function automatic int loadOf(int trp);
    return (trp == 0) ? 0 : trp - 1;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one request cycle: drive at negedge, check registered result at next negedge
  task automatic step(logic [2:0] op, logic [1:0] bank);
    logic [3:0] expCmd;
    bit expA10, expErr, legal, isIdlePre;
    logic [1:0] expBa;
    string tag;
    int b;
    b = bank;
    reqOp = op;
    reqBank = bank;
    expCmd = 4'b0111; expA10 = 0; expBa = 0; expErr = 0; tag = "R10";
    isIdlePre = !mOpen[b];
    case (op)
      3'd1: begin legal = mReady(b); tag = legal ? "R5" : "R6";
        if (legal) begin expCmd = 4'b0011; expBa = bank; end else expErr = 1; end
      3'd2, 3'd3: begin legal = mOpen[b]; tag = legal ? "R7" : "R8";
        if (legal) begin expCmd = (op == 3'd2) ? 4'b0101 : 4'b0100; expBa = bank; end
        else expErr = 1; end
      3'd4: begin tag = isIdlePre ? "R9" : "R2"; expCmd = 4'b0010; expBa = bank; end
      3'd5: begin tag = "R3"; expCmd = 4'b0010; expA10 = 1; end
      default: ;
    endcase
    @(posedge clk);
    // model update
    for (int k = 0; k < 4; k++) begin
      bit closeK;
      closeK = (op == 3'd5) || (op == 3'd4 && k == b);
      if (closeK) begin
        mOpen[k] = 0;
        mCnt[k] = loadOf(int'(trpCycles));
      end else begin
        if (op == 3'd1 && k == b && expErr == 0) mOpen[k] = 1;
        if (mCnt[k] != 0) mCnt[k]--;
      end
    end
    @(negedge clk);
    check({csN, rasN, casN, weN} == expCmd, tag, "command pins", {csN, rasN, casN, weN}, expCmd);
    check(a10 == expA10, tag, "a10", a10, expA10);
    check(ba == expBa, tag, "ba", ba, expBa);
    check(errPulse == expErr, tag, "errPulse", errPulse, expErr);
    check(bankReady == mReadyVec(), "R4", "bankReady", bankReady, mReadyVec());
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h5eed_1234);
    for (int b = 0; b < 4; b++) begin mOpen[b] = 0; mCnt[b] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check({csN, rasN, casN, weN} == 4'b0111, "R1", "reset pins", {csN, rasN, casN, weN}, 4'b0111);
    check(a10 == 0 && ba == 0, "R1", "reset a10/ba", {a10, ba}, 0);
    check(bankReady == 4'hF, "R1", "reset ready", bankReady, 4'hF);
    check(errPulse == 0, "R1", "reset err", errPulse, 0);

    // directed: open, access, close bank 2 with tRP 5
    trpCycles = 4'd5;
    step(3'd1, 2'd2);
    step(3'd1, 2'd2);            // R6: already open
    step(3'd2, 2'd2);
    step(3'd3, 2'd2);
    step(3'd2, 2'd1);            // R8: idle bank
    step(3'd4, 2'd2);            // R2
    step(3'd1, 2'd2);            // R6: recovering
    step(3'd3, 2'd2);            // R8: recovering
    repeat (2) step(3'd0, 2'd0);
    step(3'd1, 2'd2);            // R4: exact expiry, must be accepted (5 cycles after PRE)
    check(mOpen[2] == 1, "R4", "activation at tRP boundary", mOpen[2], 1);

    // R9 collision: reload on last recovery cycle
    trpCycles = 4'd3;
    step(3'd4, 2'd1);
    step(3'd0, 2'd0);
    step(3'd4, 2'd1);            // reload when countdown would expire
    step(3'd1, 2'd1);            // rejected: new window
    step(3'd0, 2'd0);
    step(3'd1, 2'd1);            // accepted

    // R3 all-bank close, tRP 0 and 1 corners
    trpCycles = 4'd0;
    step(3'd5, 2'd3);
    step(3'd1, 2'd0);
    trpCycles = 4'd1;
    step(3'd5, 2'd1);
    step(3'd1, 2'd3);
    step(3'd6, 2'd2);            // R10
    step(3'd7, 2'd1);            // R10

    // constrained random traffic
    for (int seg = 0; seg < 60; seg++) begin
      trpCycles = TRP_W'($urandom_range(0, 7));
      for (int i = 0; i < 50; i++) begin
        int r;
        logic [2:0] op;
        r = $urandom_range(0, 99);
        if (r < 30) op = 3'd1;
        else if (r < 50) op = 3'd2;
        else if (r < 65) op = 3'd3;
        else if (r < 80) op = 3'd4;
        else if (r < 85) op = 3'd5;
        else op = 3'($urandom_range(0, 1) ? 0 : $urandom_range(6, 7));
        step(op, 2'($urandom_range(0, 3)));
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule